// File: doc/BRIEF.md
# DS3 Receive Framing Monitor

This block is the register-facing control and monitoring layer that sits beside a DS3 receive frame aligner. The aligner reports each change in its alignment as single-cycle pulses: one when alignment is lost and one when alignment is regained. It also pulses once for each bad F framing bit and once for each bad M framing bit. From these pulses the block keeps the out-of-frame state. It drives that state onto a pin and into a status register, and it latches a change-of-state interrupt. It also keeps a saturating 16-bit count of framing-bit errors, which clears when it is read.

Software reaches the block through a byte-wide register port with separate read and write strobes. A write can order the aligner back into F-bit search. The same write sets out-of-frame at once, and the resulting change raises an interrupt. Four configuration bits are passed to the aligner as level outputs. The count is read as two bytes. Reading the high byte freezes the whole count so that the two reads never disagree.

Top module: `ds3_frm_mon`

## Requirements
- R1: After reset, oof_o is 1, irq_o is 0, reframe_o is 0, rd_data_o is 0x00, cfg_o is 0, the interrupt enable is 0 and the error count is 0.
- R2: A write of a value with bit 0 set to address 0x01 drives reframe_o and oof_o high in the cycle after the write strobe. A write to 0x01 with bit 0 clear has no effect.
- R3: reframe_o stays high for exactly one cycle. A read of 0x01 in any later cycle returns 0x00.
- R4: A lost_i pulse sets oof_o from the next cycle. A regain_i pulse alone clears it. When both pulses arrive in the same cycle, out-of-frame is set.
- R5: Register 0x10 reads as bit 7 = ais_i, bit 6 = los_i, bit 5 = idle_i, bit 4 = out-of-frame, and bits 3..0 = cfg_o. A write to 0x10 updates only bits 3..0. Those bits are cfg_o: bit 3 = LOS interrupt disable, bit 2 = parity-based framing, bit 1 = F-sync algorithm, bit 0 = M-sync algorithm.
- R6: Every change of out-of-frame, in either direction, sets the flag at bit 0 of 0x12. The flag holds until 0x12 is read; that read returns 1 and clears it. irq_o equals the flag ANDed with the enable at bit 0 of 0x11, delayed by one cycle.
- R7: Each fbit_err_i pulse and each mbit_err_i pulse adds one to the error count. Two pulses in the same cycle add two.
- R8: A read of 0x52 returns bits 15..8 of the live count, copies the whole count into a holding register and restarts the live count. An error pulse in the cycle of that read counts as the first error of the new period. A read of 0x53 returns bits 7..0 of the holding register and then clears it.
- R9: The error count stops at 0xFFFF and does not wrap.
- R10: Read data appears on rd_data_o in the cycle after the read strobe. Addresses with no register read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| lost_i | input | 1 | Aligner lost-alignment pulse |
| regain_i | input | 1 | Aligner regained-alignment pulse |
| fbit_err_i | input | 1 | F-bit error pulse |
| mbit_err_i | input | 1 | M-bit error pulse |
| ais_i | input | 1 | AIS detected level |
| los_i | input | 1 | Loss of signal level |
| idle_i | input | 1 | Idle pattern level |
| oof_o | output | 1 | Out-of-frame state |
| reframe_o | output | 1 | One-cycle command to restart F-bit search |
| cfg_o | output | 4 | Aligner configuration bits |
| irq_o | output | 1 | Change-of-frame-state interrupt |

## Verification
The assertions assume that wr_en_i and rd_en_i are never high in the same cycle. They also assume that the aligner pulses and error pulses are synchronous to clk and carry meaning only while reset is low. The stimulus drives all inputs at the falling edge, and only one register access is ever open at a time. Pulses are held for exactly one cycle, except for the deliberate same-cycle lost/regain case and the long run of continuous errors that drives the counter to its ceiling.

// File: rtl/ds3m_pkg.sv
package ds3m_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int CFG_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h01;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] A_IEN    = 8'h11;
  localparam logic [ADDR_W-1:0] A_ISTAT  = 8'h12;
  localparam logic [ADDR_W-1:0] A_ERR_HI = 8'h52;
  localparam logic [ADDR_W-1:0] A_ERR_LO = 8'h53;

  typedef struct packed {
    logic ais;
    logic los;
    logic idle;
  } line_stat_t;
endpackage

// File: rtl/ds3m_oof.sv
module ds3m_oof (
  input  logic clk,
  input  logic rst,
  input  logic force_i,
  input  logic lost_i,
  input  logic regain_i,
  input  logic flag_clr_i,
  input  logic irq_en_i,
  output logic oof_o,
  output logic flag_o,
  output logic irq_o
);
  logic oof_q, oof_d;
  logic flag_q;
  logic irq_q;

  always_comb begin
    oof_d = oof_q;
    if (force_i || lost_i)
      oof_d = 1'b1;
    else if (regain_i)
      oof_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oof_q  <= 1'b1;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      oof_q <= oof_d;
      if (oof_d != oof_q)
        flag_q <= 1'b1;
      else if (flag_clr_i)
        flag_q <= 1'b0;
      irq_q <= flag_q & irq_en_i;
    end
  end

  assign oof_o  = oof_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ds3m_errcnt.sv
module ds3m_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fbit_i,
  input  logic             mbit_i,
  input  logic             take_i,
  input  logic             drop_i,
  output logic [CNT_W-1:0] live_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W:0] MAX_W = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] live_q, hold_q, base;
  logic [1:0]       inc;
  logic [CNT_W:0]   sum;

  always_comb begin
    inc  = {1'b0, fbit_i} + {1'b0, mbit_i};
    base = take_i ? '0 : live_q;
    sum  = {1'b0, base} + {{(CNT_W-1){1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      hold_q <= '0;
    end else begin
      live_q <= (sum > MAX_W) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      if (take_i)
        hold_q <= live_q;
      else if (drop_i)
        hold_q <= '0;
    end
  end

  assign live_o = live_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/ds3m_regs.sv
module ds3m_regs
  import ds3m_pkg::*;
#(
  parameter int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  line_stat_t        line_i,
  input  logic              oof_i,
  input  logic              flag_i,
  input  logic [CNT_W-1:0]  live_i,
  input  logic [CNT_W-1:0]  hold_i,
  output logic              force_o,
  output logic              reframe_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              irq_en_o,
  output logic              flag_clr_o,
  output logic              take_o,
  output logic              drop_o
);
  logic [CFG_W-1:0]  cfg_q;
  logic              ien_q;
  logic              refr_q;
  logic [DATA_W-1:0] rd_q, rd_mux;

  assign force_o    = wr_en_i && (addr_i == A_CTRL) && wr_data_i[0];
  assign flag_clr_o = rd_en_i && (addr_i == A_ISTAT);
  assign take_o     = rd_en_i && (addr_i == A_ERR_HI);
  assign drop_o     = rd_en_i && (addr_i == A_ERR_LO);

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rd_mux = {{(DATA_W-1){1'b0}}, refr_q};
      A_STAT:   rd_mux = {line_i.ais, line_i.los, line_i.idle, oof_i, cfg_q};
      A_IEN:    rd_mux = {{(DATA_W-1){1'b0}}, ien_q};
      A_ISTAT:  rd_mux = {{(DATA_W-1){1'b0}}, flag_i};
      A_ERR_HI: rd_mux = live_i[CNT_W-1 -: DATA_W];
      A_ERR_LO: rd_mux = hold_i[DATA_W-1:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      ien_q  <= 1'b0;
      refr_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      refr_q <= force_o;
      if (wr_en_i && addr_i == A_STAT)
        cfg_q <= wr_data_i[CFG_W-1:0];
      if (wr_en_i && addr_i == A_IEN)
        ien_q <= wr_data_i[0];
      if (rd_en_i)
        rd_q <= rd_mux;
    end
  end

  assign rd_data_o = rd_q;
  assign reframe_o = refr_q;
  assign cfg_o     = cfg_q;
  assign irq_en_o  = ien_q;
endmodule

// File: rtl/ds3_frm_mon.sv
module ds3_frm_mon
  import ds3m_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              lost_i,
  input  logic              regain_i,
  input  logic              fbit_err_i,
  input  logic              mbit_err_i,
  input  logic              ais_i,
  input  logic              los_i,
  input  logic              idle_i,
  output logic              oof_o,
  output logic              reframe_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic             force_s, flag_s, ien_s, flag_clr_s, take_s, drop_s;
  logic [CNT_W-1:0] live_s, hold_s;
  line_stat_t       line_s;

  assign line_s = '{ais: ais_i, los: los_i, idle: idle_i};

  ds3m_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .line_i(line_s), .oof_i(oof_o), .flag_i(flag_s),
    .live_i(live_s), .hold_i(hold_s),
    .force_o(force_s), .reframe_o(reframe_o), .cfg_o(cfg_o),
    .irq_en_o(ien_s), .flag_clr_o(flag_clr_s),
    .take_o(take_s), .drop_o(drop_s)
  );

  ds3m_oof u_oof (
    .clk(clk), .rst(rst),
    .force_i(force_s), .lost_i(lost_i), .regain_i(regain_i),
    .flag_clr_i(flag_clr_s), .irq_en_i(ien_s),
    .oof_o(oof_o), .flag_o(flag_s), .irq_o(irq_o)
  );

  ds3m_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .fbit_i(fbit_err_i), .mbit_i(mbit_err_i),
    .take_i(take_s), .drop_i(drop_s),
    .live_o(live_s), .hold_o(hold_s)
  );
endmodule

// File: rtl/ds3m_chk.sv
module ds3m_chk
  import ds3m_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              lost_i,
  input logic              regain_i,
  input logic              fbit_err_i,
  input logic              mbit_err_i,
  input logic              oof_o,
  input logic              reframe_o,
  input logic              irq_o,
  input logic              flag_s,
  input logic              ien_s,
  input logic [15:0]       live_s
);
  logic frc;
  assign frc = wr_en_i && addr_i == A_CTRL && wr_data_i[0];

  a_r2_reframe_sets_oof: assert property (@(posedge clk) disable iff (rst)
    frc |=> (oof_o && reframe_o));
  a_r3_reframe_single: assert property (@(posedge clk) disable iff (rst)
    (reframe_o && !frc) |=> !reframe_o);
  a_r4_lost_sets_oof: assert property (@(posedge clk) disable iff (rst)
    lost_i |=> oof_o);
  a_r4_regain_clears: assert property (@(posedge clk) disable iff (rst)
    (regain_i && !lost_i && !frc) |=> !oof_o);
  a_r6_change_flags: assert property (@(posedge clk) disable iff (rst)
    (oof_o != $past(oof_o)) |-> flag_s);
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ien_s |=> !irq_o);
  a_r7_count_up: assert property (@(posedge clk) disable iff (rst)
    ((fbit_err_i || mbit_err_i) && !(rd_en_i && addr_i == A_ERR_HI) && live_s != 16'hFFFF)
      |=> live_s > $past(live_s));
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (live_s == 16'hFFFF && !(rd_en_i && addr_i == A_ERR_HI)) |=> live_s == 16'hFFFF);
  a_r10_no_dual_access: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && rd_en_i));
endmodule

bind ds3_frm_mon ds3m_chk u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wr_data_i(wr_data_i), .lost_i(lost_i),
  .regain_i(regain_i), .fbit_err_i(fbit_err_i), .mbit_err_i(mbit_err_i),
  .oof_o(oof_o), .reframe_o(reframe_o), .irq_o(irq_o),
  .flag_s(flag_s), .ien_s(ien_s), .live_s(live_s)
);

// File: tb/tb_ds3_frm_mon.sv
module tb_ds3_frm_mon;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       lost = 1'b0, regain = 1'b0, fbit = 1'b0, mbit = 1'b0;
  logic       ais = 1'b0, los = 1'b0, idle = 1'b0;
  logic       oof, refr, irq;
  logic [3:0] cfg;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ds3_frm_mon dut (
    .clk(clk), .rst(rst), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .lost_i(lost), .regain_i(regain),
    .fbit_err_i(fbit), .mbit_err_i(mbit), .ais_i(ais), .los_i(los),
    .idle_i(idle), .oof_o(oof), .reframe_o(refr), .cfg_o(cfg), .irq_o(irq)
  );

  // {is_write, addr, data, expected read}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h10, 8'hFF, 8'h00},
    {1'b0, 8'h10, 8'h00, 8'hBF},
    {1'b1, 8'h10, 8'h05, 8'h00},
    {1'b0, 8'h10, 8'h00, 8'hB5},
    {1'b1, 8'h11, 8'h01, 8'h00},
    {1'b0, 8'h11, 8'h00, 8'h01},
    {1'b1, 8'h11, 8'h00, 8'h00},
    {1'b0, 8'h11, 8'h00, 8'h00},
    {1'b0, 8'h99, 8'h00, 8'h00},
    {1'b0, 8'h01, 8'h00, 8'h00},
    {1'b0, 8'h12, 8'h00, 8'h00},
    {1'b0, 8'h52, 8'h00, 8'h00},
    {1'b0, 8'h53, 8'h00, 8'h00},
    {1'b0, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, string tag, logic [7:0] exp);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    chk(tag, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 oof", {15'd0, oof}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 reframe", {15'd0, refr}, 16'd0);
    chk("R1 rdata", {8'd0, rdata}, 16'd0);
    chk("R1 cfg", {12'd0, cfg}, 16'd0);

    // R5 R10 table walk with line status levels set
    ais = 1'b1; idle = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) wr_reg(VEC[i][23:16], VEC[i][15:8]);
      else rd_reg(VEC[i][23:16], "R5/R10 table read", VEC[i][7:0]);
    end
    chk("R5 cfg pins", {12'd0, cfg}, 16'h0005);

    // R4 R6 regain clears, flag latched, read clears it
    pulse(regain);
    chk("R4 regain clears oof", {15'd0, oof}, 16'd0);
    rd_reg(8'h12, "R6 flag after leaving oof", 8'h01);
    rd_reg(8'h12, "R6 flag cleared by read", 8'h00);

    // R6 interrupt pin with enable
    wr_reg(8'h11, 8'h01);
    pulse(lost);
    chk("R4 lost sets oof", {15'd0, oof}, 16'd1);
    @(negedge clk);
    chk("R6 irq asserted", {15'd0, irq}, 16'd1);
    rd_reg(8'h12, "R6 flag after entering oof", 8'h01);
    @(negedge clk);
    chk("R6 irq drops after read", {15'd0, irq}, 16'd0);
    wr_reg(8'h11, 8'h00);

    // R4 simultaneous lost and regain
    @(negedge clk); lost = 1'b1; regain = 1'b1;
    @(negedge clk); lost = 1'b0; regain = 1'b0;
    chk("R4 lost wins", {15'd0, oof}, 16'd1);
    pulse(regain);
    rd_reg(8'h12, "R6 clear before reframe", 8'h01);

    // R2 R3 software reframe
    wr_reg(8'h01, 8'h01);
    chk("R2 reframe pulse", {15'd0, refr}, 16'd1);
    chk("R2 oof forced", {15'd0, oof}, 16'd1);
    @(negedge clk);
    chk("R3 reframe single cycle", {15'd0, refr}, 16'd0);
    rd_reg(8'h01, "R3 reframe self clears", 8'h00);
    rd_reg(8'h12, "R6 flag from reframe", 8'h01);
    pulse(regain);
    rd_reg(8'h12, "R6 flag from regain", 8'h01);
    wr_reg(8'h01, 8'h00);
    chk("R2 zero write no reframe", {15'd0, refr}, 16'd0);
    chk("R2 zero write keeps oof", {15'd0, oof}, 16'd0);

    // R7 combined counting
    rd_reg(8'h52, "R7 pre-clear hi", 8'h00);
    rd_reg(8'h53, "R7 pre-clear lo", 8'h00);
    repeat (3) pulse(fbit);
    repeat (2) pulse(mbit);
    @(negedge clk); fbit = 1'b1; mbit = 1'b1;
    @(negedge clk); fbit = 1'b0; mbit = 1'b0;
    rd_reg(8'h52, "R7 count hi", 8'h00);
    rd_reg(8'h53, "R7 count lo", 8'h07);
    rd_reg(8'h52, "R8 cleared hi", 8'h00);
    rd_reg(8'h53, "R8 cleared lo", 8'h00);

    // R8 snapshot holds across reads
    @(negedge clk); fbit = 1'b1;
    repeat (300) @(negedge clk);
    fbit = 1'b0;
    rd_reg(8'h52, "R8 hi of 300", 8'h01);
    repeat (5) pulse(mbit);
    rd_reg(8'h53, "R8 lo snapshot", 8'h2C);
    rd_reg(8'h52, "R8 new period hi", 8'h00);
    rd_reg(8'h53, "R8 new period lo", 8'h05);

    // R8 error in the cycle of the clearing read
    @(negedge clk); rd = 1'b1; addr = 8'h52; fbit = 1'b1;
    @(negedge clk); rd = 1'b0; fbit = 1'b0;
    rd_reg(8'h52, "R8 same-cycle hi", 8'h00);
    rd_reg(8'h53, "R8 same-cycle lo", 8'h01);

    // R9 saturation
    @(negedge clk); fbit = 1'b1; mbit = 1'b1;
    repeat (33000) @(negedge clk);
    fbit = 1'b0; mbit = 1'b0;
    rd_reg(8'h52, "R9 saturated hi", 8'hFF);
    rd_reg(8'h53, "R9 saturated lo", 8'hFF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule